// File: doc/BRIEF.md
# Six-Channel PWM with Triggered Shadow Commit

This block produces six independent pulse-width waveforms from one input clock. Each channel has a clock prescaler, a period count, a high-time count and a polarity select. Software programs these through a word-wide register bus. Bus writes land only in shadow storage. The live waveform generator of a channel adopts them when that channel's trigger bit rises.

A per-channel smooth bit picks the moment of adoption. With smooth clear, the channel takes the new settings on the next clock and restarts its period. With smooth set, the channel finishes the current period and switches at the boundary. A channel with both trigger and smooth low drives a constant high level. There is no enable. Software idles a channel by committing a zero high time.

The usual update sequence has three steps. First raise smooth and drop trigger, which holds the old waveform. Then write the new fields. Finally raise trigger.

Top module: `trig_pwm`

## Requirements
- R1: After reset, every register reads zero and all six outputs are high.
- R2: The registers read back as written, and unimplemented bits read zero. The control word at 0x00 holds trigger in bits [5:0], polarity in [13:8], output type in [21:16] and smooth in [29:24], with bit n of each group belonging to channel n. The word at 0x04 holds a 3-bit prescale for channel n at bit 4n. The 24-bit period of channel n is at 0x08+8n and its 24-bit high time is at 0x0C+8n.
- R3: Writing prescale, period, high time or polarity leaves the running waveform of a channel unchanged until that channel's trigger bit rises.
- R4: Suppose a trigger rise with smooth clear is written on clock edge k. On the following edge k+1, all shadow fields of that channel are committed together, and a new period starts at count zero.
- R5: Suppose a trigger rise with smooth set. The old waveform continues to the end of its current period, and the new settings start at the following period boundary.
- R6: While both the trigger bit and the smooth bit of a channel are low, its output is constantly high.
- R7: With prescale p, period P ≥ 2 and high time D < P, the period lasts (p+1)·P clocks. With polarity 1, the output is high for the first (p+1)·D of those clocks and low for the rest.
- R8: With polarity 0, the output is the inverse of the polarity-1 waveform.
- R9: A high time of zero holds the output at its inactive level. A high time of P or more holds it at its active level.
- R10: A period count below 2 holds the output at its inactive level, whatever the high time.
- R11: Each channel is independent: a configuration or trigger on one channel leaves the other outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; also the count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pwm_o | output | 6 | Waveform of each channel |

## Verification
The bound checker watches four things on every cycle: the forced-high level, the inactive and active levels for zero high time, short periods and full high time, and the one-cycle commit after a trigger rise with smooth clear. It also checks that the live settings never change without a trigger rise or a pending smooth commit. Only the directed scenarios can show the exact waveform shape across prescale values and the boundary cycle of a smooth switch. The same holds for the register bit layout and for the way the old and new waveforms join.

// File: rtl/trig_pwm_pkg.sv
package trig_pwm_pkg;
  localparam int unsigned NUM_CH     = 6;
  localparam int unsigned CNT_W      = 24;
  localparam int unsigned PRE_W      = 3;
  localparam int unsigned DW         = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned PRE_STRIDE = 4;
  localparam int unsigned CH_STRIDE  = 8;
  // control word groups
  localparam int unsigned GRP_TRIG   = 0;
  localparam int unsigned GRP_POL    = 8;
  localparam int unsigned GRP_TYPE   = 16;
  localparam int unsigned GRP_SMOOTH = 24;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PRESC  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PERIOD = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_DUTY   = 8'h0C;

  typedef struct packed {
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic             pol;
  } chan_cfg_t;
endpackage

// File: rtl/trig_pwm_regs.sv
module trig_pwm_regs
  import trig_pwm_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output chan_cfg_t [NUM_CH-1:0]   cfg_o,
  output logic [NUM_CH-1:0]        trig_o,
  output logic [NUM_CH-1:0]        smooth_o
);
  logic [NUM_CH-1:0]            trig_q, pol_q, type_q, smooth_q;
  logic [NUM_CH-1:0][PRE_W-1:0] presc_q;
  logic [NUM_CH-1:0][CNT_W-1:0] per_q, duty_q;

  function automatic logic [ADDR_W-1:0] per_addr(input int unsigned ch);
    return ADDR_W'(OFF_PERIOD + ch * CH_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] duty_addr(input int unsigned ch);
    return ADDR_W'(OFF_DUTY + ch * CH_STRIDE);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q   <= '0;
      pol_q    <= '0;
      type_q   <= '0;
      smooth_q <= '0;
      presc_q  <= '0;
      per_q    <= '0;
      duty_q   <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_CTRL) begin
        trig_q   <= wdata_i[GRP_TRIG   +: NUM_CH];
        pol_q    <= wdata_i[GRP_POL    +: NUM_CH];
        type_q   <= wdata_i[GRP_TYPE   +: NUM_CH];
        smooth_q <= wdata_i[GRP_SMOOTH +: NUM_CH];
      end
      if (addr_i == OFF_PRESC) begin
        for (int c = 0; c < NUM_CH; c++) presc_q[c] <= wdata_i[c*PRE_STRIDE +: PRE_W];
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr_i == per_addr(c))  per_q[c]  <= wdata_i[CNT_W-1:0];
        if (addr_i == duty_addr(c)) duty_q[c] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_CTRL) begin
      rdata_o[GRP_TRIG   +: NUM_CH] = trig_q;
      rdata_o[GRP_POL    +: NUM_CH] = pol_q;
      rdata_o[GRP_TYPE   +: NUM_CH] = type_q;
      rdata_o[GRP_SMOOTH +: NUM_CH] = smooth_q;
    end
    if (addr_i == OFF_PRESC) begin
      for (int c = 0; c < NUM_CH; c++) rdata_o[c*PRE_STRIDE +: PRE_W] = presc_q[c];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == per_addr(c))  rdata_o[CNT_W-1:0] = per_q[c];
      if (addr_i == duty_addr(c)) rdata_o[CNT_W-1:0] = duty_q[c];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cfg
    assign cfg_o[g].presc  = presc_q[g];
    assign cfg_o[g].period = per_q[g];
    assign cfg_o[g].duty   = duty_q[g];
    assign cfg_o[g].pol    = pol_q[g];
  end

  assign trig_o   = trig_q;
  assign smooth_o = smooth_q;
endmodule

// File: rtl/trig_pwm_chan.sv
module trig_pwm_chan
  import trig_pwm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  chan_cfg_t cfg_i,
  input  logic      trig_i,
  input  logic      smooth_i,
  output logic      pwm_o,
  output chan_cfg_t live_o,
  output logic      pend_o
);
  chan_cfg_t        live_q;
  logic             trig_q, pend_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             rise, tick, boundary, commit, active;

  assign rise     = trig_i & ~trig_q;
  assign tick     = (pre_q == live_q.presc);
  assign cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
  // periods of 0 or 1 end on every tick
  assign boundary = tick && (cnt_inc >= {1'b0, live_q.period});
  assign commit   = (rise & ~smooth_i) | (boundary & (pend_q | (rise & smooth_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      pend_q <= 1'b0;
      live_q <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig_i;
      if (commit) begin
        live_q <= cfg_i;
        pend_q <= 1'b0;
        pre_q  <= '0;
        cnt_q  <= '0;
      end else begin
        if (rise && smooth_i) pend_q <= 1'b1;
        if (tick) begin
          pre_q <= '0;
          cnt_q <= boundary ? '0 : cnt_inc[CNT_W-1:0];
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end

  assign active = (live_q.period >= CNT_W'(2)) && (cnt_q < live_q.duty);
  assign pwm_o  = (~trig_i & ~smooth_i) | (live_q.pol ? active : ~active);
  assign live_o = live_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/trig_pwm.sv
module trig_pwm
  import trig_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  chan_cfg_t [NUM_CH-1:0] cfg_w, live_w;
  logic [NUM_CH-1:0]      trig_w, smooth_w, pend_w;

  trig_pwm_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .cfg_o    (cfg_w),
    .trig_o   (trig_w),
    .smooth_o (smooth_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    trig_pwm_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_i    (cfg_w[g]),
      .trig_i   (trig_w[g]),
      .smooth_i (smooth_w[g]),
      .pwm_o    (pwm_o[g]),
      .live_o   (live_w[g]),
      .pend_o   (pend_w[g])
    );
  end
endmodule

// File: rtl/trig_pwm_chk.sv
module trig_pwm_chk
  import trig_pwm_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_CH-1:0]      pwm_i,
  input logic [NUM_CH-1:0]      trig_i,
  input logic [NUM_CH-1:0]      smooth_i,
  input logic [NUM_CH-1:0]      pend_i,
  input chan_cfg_t [NUM_CH-1:0] cfg_i,
  input chan_cfg_t [NUM_CH-1:0] live_i
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic forced, short_per, full_duty;
    assign forced    = !trig_i[g] && !smooth_i[g];
    assign short_per = live_i[g].period < CNT_W'(2);
    assign full_duty = live_i[g].duty >= live_i[g].period;

    p_force_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      forced |-> pwm_i[g]);

    p_zero_duty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!forced && live_i[g].duty == '0) |-> (pwm_i[g] == !live_i[g].pol));

    p_full_duty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!forced && !short_per && full_duty) |-> (pwm_i[g] == live_i[g].pol));

    p_short_period_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!forced && short_per) |-> (pwm_i[g] == !live_i[g].pol));

    p_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(trig_i[g]) && !smooth_i[g]) |=> (live_i[g] == $past(cfg_i[g])));

    p_shadow_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$rose(trig_i[g]) && !pend_i[g]) |=> $stable(live_i[g]));
  end
endmodule

bind trig_pwm trig_pwm_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwm_i    (pwm_o),
  .trig_i   (trig_w),
  .smooth_i (smooth_w),
  .pend_i   (pend_w),
  .cfg_i    (cfg_w),
  .live_i   (live_w)
);

// File: tb/trig_pwm_bench.sv
`timescale 1ns/1ps
module trig_pwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  pwm;

  int nvec = 0;
  int nfail = 0;
  int ph = 0;
  logic [31:0] ctrl_sh = '0;
  logic [31:0] presc_sh = '0;

  always #2 clk = ~clk;

  trig_pwm u_trig_pwm (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm)
  );

  task automatic step();
    @(negedge clk);
    ph++;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step();
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic wave(input int p, input int per, input int d, input logic pol, input int i);
    logic a;
    if (per < 2) a = 1'b0;
    else a = ((i / (p + 1)) % per) < d;
    return pol ? a : !a;
  endfunction

  // prepare with smooth, load shadows, commit immediately; state 0 on return
  task automatic cfg_ch(input int ch, input int p, input int per, input int d, input logic pol);
    ctrl_sh[24+ch] = 1'b1; ctrl_sh[ch] = 1'b0; ctrl_sh[8+ch] = pol;
    wr(8'h00, ctrl_sh);
    presc_sh[ch*4 +: 3] = 3'(p);
    wr(8'h04, presc_sh);
    wr(8'(8 + ch*8), 32'(per));
    wr(8'(12 + ch*8), 32'(d));
    ctrl_sh[24+ch] = 1'b0; ctrl_sh[ch] = 1'b1;
    wr(8'h00, ctrl_sh);
    step();
    ph = 0;
  endtask

  task automatic expect_wave(input int ch, input int p, input int per, input int d,
                             input logic pol, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(req, 32'(pwm[ch]), 32'(wave(p, per, d, pol, ph)));
      step();
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 outputs", 32'(pwm), 32'h3F);
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h04, v); chk("R1 presc", v, 0);
    rd(8'h08, v); chk("R1 period0", v, 0);
    rd(8'h34, v); chk("R1 duty5", v, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h30, 32'hABCD_EF12);
    wr(8'h1C, 32'h1234_5678);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R2 presc", v, 32'h0077_7777);
    rd(8'h30, v); chk("R2 period5", v, 32'h00CD_EF12);
    rd(8'h1C, v); chk("R2 duty2", v, 32'h0034_5678);
    rd(8'h00, v); chk("R2 ctrl", v, 32'h3F3F_3F3F);
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    chk("R6 all forced", 32'(pwm), 32'h3F);
  endtask

  task automatic t_basic();
    cfg_ch(0, 0, 8, 3, 1'b1);
    chk("R11 others", 32'(pwm[5:1]), 32'h1F);
    expect_wave(0, 0, 8, 3, 1'b1, 24, "R4 R7 ch0");
  endtask

  task automatic t_presc();
    cfg_ch(1, 2, 5, 2, 1'b1);
    expect_wave(1, 2, 5, 2, 1'b1, 30, "R7 ch1");
  endtask

  task automatic t_invert();
    cfg_ch(2, 1, 6, 4, 1'b0);
    expect_wave(2, 1, 6, 4, 1'b0, 24, "R8 ch2");
  endtask

  task automatic t_edges();
    cfg_ch(3, 0, 7, 0, 1'b1);
    expect_wave(3, 0, 7, 0, 1'b1, 14, "R9 zero");
    cfg_ch(3, 0, 7, 9, 1'b1);
    expect_wave(3, 0, 7, 9, 1'b1, 14, "R9 full");
    cfg_ch(3, 0, 1, 1, 1'b1);
    expect_wave(3, 0, 1, 1, 1'b1, 6, "R10 one");
    cfg_ch(3, 1, 0, 5, 1'b0);
    expect_wave(3, 1, 0, 5, 1'b0, 6, "R10 zero");
  endtask

  task automatic t_smooth();
    int j;
    cfg_ch(4, 0, 10, 5, 1'b1);
    expect_wave(4, 0, 10, 5, 1'b1, 12, "R7 ch4");
    ctrl_sh[28] = 1'b1; ctrl_sh[4] = 1'b0; ctrl_sh[12] = 1'b0;
    wr(8'h00, ctrl_sh);
    wr(8'h28, 32'd4);
    wr(8'h2C, 32'd1);
    expect_wave(4, 0, 10, 5, 1'b1, 5, "R3 shadow");
    ctrl_sh[4] = 1'b1;
    wr(8'h00, ctrl_sh);
    j = ((ph / 10) + 1) * 10;
    while (ph < j + 16) begin
      if (ph < j) chk("R5 old", 32'(pwm[4]), 32'(wave(0, 10, 5, 1'b1, ph)));
      else        chk("R5 new", 32'(pwm[4]), 32'(wave(0, 4, 1, 1'b0, ph - j)));
      step();
    end
  endtask

  task automatic t_force();
    ctrl_sh[2] = 1'b0; ctrl_sh[26] = 1'b0;
    wr(8'h00, ctrl_sh);
    for (int k = 0; k < 8; k++) begin
      chk("R6 ch2 high", 32'(pwm[2]), 32'h1);
      step();
    end
  endtask

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_basic();
    t_presc();
    t_invert();
    t_edges();
    t_smooth();
    t_force();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule